// File: doc/BRIEF.md
# I2C Bus Control State Tracker

This block watches an already synchronized I2C clock and data line pair, together with a local master-request handshake, and keeps a three-bit bus state code that software can read at any time. It recognises START and STOP conditions, tells a free bus from a busy one, and notices when a remote master has begun an access. It then decodes the first address byte of that access against the local slave address. When the local master engine is asked for a transfer and reports that it has begun, the tracker enters a dedicated master state.

The code values are fixed and software-visible. Codes 0 and 7 are never produced. A separate "unknown" code is held after reset until the tracker can be sure the bus is idle. The tracker does not shift data or drive acknowledges; it only observes.

Top module: `i2c_bus_tracker`

## Requirements
- R1: After reset the state output reads 6 (bus condition unknown).
- R2: In state 6, a STOP condition (SDA rising while SCL is high and was high) moves the state to 4 (free) at the clock edge that samples it.
- R3: In state 6, when both lines are sampled high on IDLE_CYC consecutive clock edges, the state becomes 4 at the last of those edges; any edge with either line low restarts the count.
- R4: In every state other than 6, a STOP moves the state to 4.
- R5: In state 4 with no master request pending, a START (SDA falling while SCL is high and was high) moves the state to 2 (slave access, address not yet decoded); a START in state 1 or 5 also returns to 2.
- R6: In state 2, the first ADDR_W data bits after the START, sampled on SCL rising edges, most significant bit first, form an address; on the following SCL rising edge (the read/write bit) the state becomes 1 if that address equals own_addr_i, otherwise 5.
- R7: A one-cycle pulse on mst_req_i makes a request pending; in state 4 with a request pending, mst_started_i moves the state to 3 and clears the request. A START in state 4 while a request is pending is taken as local and leaves the state at 4; mst_started_i with nothing pending is ignored.
- R8: The state output never reads 0 or 7.
- R9: In state 3, a repeated START and SCL/SDA bit traffic leave the state at 3; only a STOP leaves it.
- R10: In state 6, a START leaves the state at 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronized I2C clock line |
| sda_i | input | 1 | Synchronized I2C data line |
| own_addr_i | input | ADDR_W | Local slave address |
| mst_req_i | input | 1 | One-cycle strobe: a master transfer has been requested |
| mst_started_i | input | 1 | The local master engine has begun its bus operation |
| state_o | output | 3 | Encoded bus state: 1 selected, 2 slave decode, 3 master, 4 free, 5 busy, 6 unknown |

## Verification
The bench builds the tracker with ADDR_W at its default of 7 and IDLE_CYC lowered to 12. This makes the idle-time exit from the unknown state, and its restart after a low line, checkable to the exact edge within a few dozen cycles. Random slave addresses, both matching and not matching the local one, drive the decode outcome. Master transfers with repeated STARTs and slave accesses that restart after a mismatch cover the transitions between states 1, 2, 3 and 5.

// File: rtl/i2c_trk_pkg.sv
package i2c_trk_pkg;
  typedef enum logic [2:0] {
    ST_SEL  = 3'd1,
    ST_SXF  = 3'd2,
    ST_MST  = 3'd3,
    ST_FREE = 3'd4,
    ST_BUSY = 3'd5,
    ST_UNK  = 3'd6
  } trk_state_e;
endpackage

// File: rtl/i2c_trk_cond.sv
// Line condition detector: START, STOP, SCL rising edge and both-lines-high.
module i2c_trk_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic idle_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    start_o    = scl_i & scl_q & sda_q & ~sda_i;
    stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    scl_rise_o = scl_i & ~scl_q;
    idle_o     = scl_i & sda_i;
  end
endmodule

// File: rtl/i2c_trk_addr.sv
// Address byte collector: shifts the first ADDR_W bits after a START and
// flags the read/write bit edge.
module i2c_trk_addr #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              scl_rise_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              done_o,
  output logic              hit_o
);
  localparam int CNT_W = $clog2(ADDR_W + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(ADDR_W + 1);

  logic [ADDR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              en;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = '0;
    end else if (scl_rise_i && (cnt_q <= CNT_LAST)) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q < CNT_LAST) sh_d = {sh_q[ADDR_W-2:0], sda_i};
    end
    en     = start_i | scl_rise_i;
    done_o = scl_rise_i & ~start_i & (cnt_q == CNT_LAST);
    hit_o  = (sh_q == own_addr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= CNT_SAT;
    end else if (en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // R6: the decode edge is reported once per address byte
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/i2c_trk_fsm.sv
// Bus state machine with idle timer and pending-request flag.
module i2c_trk_fsm
  import i2c_trk_pkg::*;
#(
  parameter int IDLE_CYC = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       idle_i,
  input  logic       addr_done_i,
  input  logic       addr_hit_i,
  input  logic       mst_req_i,
  input  logic       mst_started_i,
  output logic [2:0] state_o
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);

  trk_state_e    state_q, state_d;
  logic          pend_q, pend_d;
  logic [IW-1:0] idle_q, idle_d;
  logic          idle_en;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q | mst_req_i;
    idle_d  = idle_q;
    unique case (state_q)
      ST_UNK: begin
        if (stop_i) begin
          state_d = ST_FREE;
        end else if (idle_i) begin
          if (idle_q == IDLE_LAST) state_d = ST_FREE;
          else                     idle_d  = idle_q + 1'b1;
        end else begin
          idle_d = '0;
        end
      end
      ST_FREE: begin
        if (pend_q && mst_started_i) begin
          state_d = ST_MST;
          pend_d  = 1'b0;
        end else if (start_i && !pend_q) begin
          state_d = ST_SXF;
        end
      end
      ST_SXF: begin
        if (stop_i)           state_d = ST_FREE;
        else if (start_i)     state_d = ST_SXF;
        else if (addr_done_i) state_d = addr_hit_i ? ST_SEL : ST_BUSY;
      end
      ST_SEL, ST_BUSY: begin
        if (stop_i)       state_d = ST_FREE;
        else if (start_i) state_d = ST_SXF;
      end
      ST_MST: begin
        if (stop_i) state_d = ST_FREE;
      end
      default: state_d = ST_UNK;
    endcase
    idle_en = (state_q == ST_UNK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_UNK;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idle_q <= '0;
    else if (idle_en) idle_q <= idle_d;
  end

  assign state_o = state_q;

  assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 3'd0) && (state_o != 3'd7));

  assert_stop_to_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && state_q != ST_UNK) |=> (state_q == ST_FREE));

  assert_unk_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNK) |=> (state_q == ST_UNK || state_q == ST_FREE));

  assert_master_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_MST) |-> ($past(state_q) == ST_FREE && $past(pend_q)));

  assert_sel_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_SEL) |-> ($past(state_q) == ST_SXF && $past(addr_hit_i)));
endmodule

// File: rtl/i2c_bus_tracker.sv
module i2c_bus_tracker #(
  parameter int ADDR_W   = 7,
  parameter int IDLE_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              mst_req_i,
  input  logic              mst_started_i,
  output logic [2:0]        state_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       start_w, stop_w, rise_w, idle_w, done_w, hit_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_trk_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_rise_o (rise_w),
    .idle_o     (idle_w)
  );

  i2c_trk_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_w),
    .scl_rise_i (rise_w),
    .sda_i      (sda_i),
    .own_addr_i (own_addr_i),
    .done_o     (done_w),
    .hit_o      (hit_w)
  );

  i2c_trk_fsm #(.IDLE_CYC(IDLE_CYC)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start_i       (start_w),
    .stop_i        (stop_w),
    .idle_i        (idle_w),
    .addr_done_i   (done_w),
    .addr_hit_i    (hit_w),
    .mst_req_i     (mst_req_i),
    .mst_started_i (mst_started_i),
    .state_o       (state_o)
  );
endmodule

// File: tb/i2c_bus_tracker_bench.sv
`timescale 1ns/1ps
module i2c_bus_tracker_bench;
  localparam int AW   = 7;
  localparam int IDLE = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          scl, sda, req, stt;
  logic [AW-1:0] own;
  logic [2:0]    state;
  int            n_run = 0;
  int            n_fail = 0;

  always #4 clk = ~clk;

  i2c_bus_tracker #(.ADDR_W(AW), .IDLE_CYC(IDLE)) u_i2c_bus_tracker (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .own_addr_i(own),
    .mst_req_i(req), .mst_started_i(stt), .state_o(state)
  );

  function automatic logic [2:0] exp_after_addr(logic [AW-1:0] a, logic [AW-1:0] o);
    return (a == o) ? 3'd1 : 3'd5;
  endfunction

  task automatic check(input logic [2:0] exp, input string tag);
    n_run++;
    if (state !== exp) begin
      n_fail++;
      $display("FAIL %s: state=%0d expected=%0d", tag, state, exp);
    end
  endtask

  task automatic step_c(input logic s, input logic d, input logic r, input logic t);
    @(negedge clk);
    scl = s; sda = d; req = r; stt = t;
    @(posedge clk);
    #2;
  endtask

  task automatic step(input logic s, input logic d);
    step_c(s, d, 1'b0, 1'b0);
  endtask

  task automatic send_bit(input logic b);
    step(1'b0, b); step(1'b1, b); step(1'b0, b);
  endtask

  task automatic send_addr(input logic [AW-1:0] a, input logic rw);
    for (int i = AW - 1; i >= 0; i--) send_bit(a[i]);
    send_bit(rw);
  endtask

  task automatic start_c();
    step(1'b0, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic stop_c();
    step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; req = 1'b0; stt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd2024));
    own = 7'h52;
    do_reset();
    #2;
    check(3'd6, "R1 reset state");
    // two synchronizer edges plus a few idle edges
    repeat (7) step(1'b1, 1'b1);
    check(3'd6, "R3 short idle keeps unknown");
    step(1'b1, 1'b0);
    check(3'd6, "R10 START ignored in unknown");
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    repeat (IDLE - 1) step(1'b1, 1'b1);
    check(3'd6, "R3 one edge short of idle time");
    step(1'b1, 1'b1);
    check(3'd4, "R3 idle time reached");

    do_reset();
    step(1'b1, 1'b1); step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    check(3'd6, "R10 START in unknown");
    step(1'b1, 1'b1);
    check(3'd4, "R2 STOP leaves unknown");

    step_c(1'b1, 1'b1, 1'b0, 1'b1);
    check(3'd4, "R7 started without request ignored");
    stop_c();
    check(3'd4, "R4 STOP in free");

    // directed: mismatch, then repeated start with match
    start_c();
    check(3'd2, "R5 remote START");
    send_addr(own ^ 7'h01, 1'b0);
    check(3'd5, "R6 mismatch gives busy");
    start_c();
    check(3'd2, "R5 repeated START from busy");
    send_addr(own, 1'b1);
    check(3'd1, "R6 match gives selected");
    send_bit(1'b0);
    check(3'd1, "R6 selected holds over ack");
    stop_c();
    check(3'd4, "R4 STOP from selected");

    for (int it = 0; it < 40; it++) begin
      int kind;
      kind = int'($urandom % 3);
      if (kind == 0) begin
        a = ($urandom % 2 == 0) ? own : AW'($urandom);
        start_c();
        check(3'd2, "R5 START from free");
        send_addr(a, 1'($urandom));
        check(exp_after_addr(a, own), "R6 address decode");
        for (int b = 0; b < int'($urandom % 9); b++) send_bit(1'($urandom));
        check(exp_after_addr(a, own), "R6 state holds over data");
        stop_c();
        check(3'd4, "R4 STOP after slave access");
      end else if (kind == 1) begin
        step_c(1'b1, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0);
        check(3'd4, "R7 local START while pending");
        step_c(1'b1, 1'b0, 1'b0, 1'b1);
        check(3'd3, "R7 master started");
        send_addr(AW'($urandom), 1'($urandom));
        check(3'd3, "R9 master holds over bits");
        start_c();
        check(3'd3, "R9 repeated START in master");
        send_bit(1'($urandom));
        stop_c();
        check(3'd4, "R4 STOP from master");
      end else begin
        a = AW'($urandom);
        start_c();
        send_addr(a, 1'b0);
        check(exp_after_addr(a, own), "R6 decode before restart");
        start_c();
        check(3'd2, "R5 restart returns to decode");
        send_addr(own, 1'b0);
        check(3'd1, "R6 match after restart");
        stop_c();
        check(3'd4, "R4 STOP after restart");
      end
      if (state == 3'd0 || state == 3'd7) check(3'd4, "R8 illegal code seen");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule